// File: doc/BRIEF.md
# Bus Address Window Decoder

This block routes one bus initiator port to a fixed set of subordinate ports, each owning an aligned window of the initiator's word address space. It compares the upper address bits against every window at once and picks the match. Only that subordinate sees the cycle signal, and it receives the address relative to its window base. Its acknowledge, error, retry, stall and read data flow back to the initiator. Strobe, write enable, write data, lock, cycle type and burst type are broadcast unchanged to all subordinates.

The decoder is purely combinational. It holds no state machine, registers nothing and adds no latency; the route changes within the same cycle as the address. Window base, window size, byte-lane granularity and which optional response outputs each subordinate implements are all compile-time parameters. A subordinate may use the initiator's granularity or a finer one. For a finer one, each initiator select bit is widened over the matching group of subordinate select bits. A subordinate that lacks an error, retry or stall output contributes a defined zero on that signal. An address outside every window selects nobody and returns a quiet response.

Top module: `wbd_addr_decoder`

## Requirements
- R1: At most one bit of `s_cyc_o` is high. It is the bit of the subordinate whose window holds `m_adr_i`, and only while `m_cyc_i` is high. All bits are low while `m_cyc_i` is low.
- R2: `s_stb_o`, `s_we_o`, `s_dat_w_o`, `s_lock_o`, `s_cti_o` and `s_bte_o` equal the matching initiator inputs at all times, whatever window is selected.
- R3: Field i of `s_adr_o` (bits `i*SUB_AW +: SUB_AW`) carries `m_adr_i - SUB_BASE[i]` while subordinate i is selected.
- R4: Subordinate i's window covers the word addresses `SUB_BASE[i]` up to `SUB_BASE[i] + 2**SUB_SIZE_LOG2[i] - 1`. The first address past either end matches no window.
- R5: While subordinate i is selected, `m_ack_o` and `m_dat_r_o` equal `s_ack_i[i]` and field i of `s_dat_r_i`. Responses from other subordinates have no effect.
- R6: `m_err_o` and `m_rty_o` follow the selected subordinate's bit when its `SUB_HAS_ERR` / `SUB_HAS_RTY` bit is 1. When that bit is 0 they are 0, even if the input is high.
- R7: `m_stall_o` follows the selected subordinate's stall bit when its `SUB_HAS_STALL` bit is 1 and is 0 otherwise.
- R8: When no subordinate is selected (address miss or `m_cyc_i` low), `m_ack_o`, `m_err_o`, `m_rty_o` and `m_stall_o` are 0 and `m_dat_r_o` is all zeros.
- R9: For a subordinate with `SUB_FINE[i]=0`, field i of `s_sel_o` (bits `i*FINE_W +: FINE_W`) carries `m_sel_i` in its low `SEL_W` bits and zeros above.
- R10: For a subordinate with `SUB_FINE[i]=1` (8-bit lanes under a coarser initiator), bit j of field i of `s_sel_o` equals `m_sel_i[j / (FINE_W/SEL_W)]`. With the defaults, select bit k drives lanes 2k and 2k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr_i | input | ADDR_W | Initiator word address |
| m_dat_w_i | input | DATA_W | Initiator write data |
| m_sel_i | input | SEL_W | Initiator select, one bit per GRAN-bit lane |
| m_cyc_i | input | 1 | Initiator cycle |
| m_stb_i | input | 1 | Initiator strobe |
| m_we_i | input | 1 | Initiator write enable |
| m_lock_i | input | 1 | Initiator lock |
| m_cti_i | input | 3 | Initiator cycle type |
| m_bte_i | input | 2 | Initiator burst type |
| m_dat_r_o | output | DATA_W | Read data returned to initiator |
| m_ack_o | output | 1 | Acknowledge to initiator |
| m_err_o | output | 1 | Error to initiator |
| m_rty_o | output | 1 | Retry to initiator |
| m_stall_o | output | 1 | Stall to initiator |
| s_adr_o | output | NUM_SUB*SUB_AW | Window-relative address, one field per subordinate |
| s_dat_w_o | output | DATA_W | Broadcast write data |
| s_sel_o | output | NUM_SUB*FINE_W | Select lanes, one field per subordinate |
| s_cyc_o | output | NUM_SUB | Cycle, one bit per subordinate |
| s_stb_o | output | 1 | Broadcast strobe |
| s_we_o | output | 1 | Broadcast write enable |
| s_lock_o | output | 1 | Broadcast lock |
| s_cti_o | output | 3 | Broadcast cycle type |
| s_bte_o | output | 2 | Broadcast burst type |
| s_dat_r_i | input | NUM_SUB*DATA_W | Read data, one field per subordinate |
| s_ack_i | input | NUM_SUB | Acknowledge per subordinate |
| s_err_i | input | NUM_SUB | Error per subordinate |
| s_rty_i | input | NUM_SUB | Retry per subordinate |
| s_stall_i | input | NUM_SUB | Stall per subordinate |

## Verification
The bench drives the first word, the last word and the words one below and one above each window. An off-by-one window compare would hit a neighbour or leave a gap there. Behind each port sit address-echo subordinates, so a wrong base subtraction or lane widening shows up directly in the returned data for every select pattern. A widener that used the wrong ratio would put bytes in the wrong lanes. The bench raises every response input of every subordinate at once. A design that forgot the defaults for missing outputs would then leak error, retry or stall, and one that OR-ed all subordinates instead of muxing would report an acknowledge that never came from the selected one.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
    localparam int CTI_W = 3;
    localparam int BTE_W = 2;

    // response bundle carried back from one subordinate
    typedef struct packed {
        logic ack;
        logic err;
        logic rty;
        logic stall;
    } wbd_resp_t;
endpackage

// File: rtl/wbd_window_match.sv
module wbd_window_match #(
    parameter int ADDR_W    = 20,
    parameter int SUB_AW    = 8,
    parameter int SIZE_LOG2 = 6,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [ADDR_W-1:0] adr_i,
    output logic              hit_o,
    output logic [SUB_AW-1:0] offset_o
);
    localparam logic [SUB_AW-1:0] OFF_MASK = SUB_AW'((64'd1 << SIZE_LOG2) - 64'd1);
    localparam logic [SUB_AW-1:0] BASE_LO  = BASE[SUB_AW-1:0];

    logic [SUB_AW-1:0] diff;

    always_comb begin
        hit_o    = (adr_i[ADDR_W-1:SIZE_LOG2] == BASE[ADDR_W-1:SIZE_LOG2]);
        diff     = adr_i[SUB_AW-1:0] - BASE_LO;
        offset_o = diff & OFF_MASK;
    end
endmodule

// File: rtl/wbd_sel_widen.sv
module wbd_sel_widen #(
    parameter int   SEL_W  = 2,
    parameter int   FINE_W = 4,
    parameter logic FINE   = 1'b0
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [FINE_W-1:0] sel_o
);
    localparam int RATIO = FINE_W / SEL_W;

    generate
        if (FINE) begin : g_fine
            for (genvar j = 0; j < FINE_W; j++) begin : g_lane
                assign sel_o[j] = sel_i[j / RATIO];
            end
        end else begin : g_coarse
            for (genvar j = 0; j < FINE_W; j++) begin : g_lane
                if (j < SEL_W) begin : g_live
                    assign sel_o[j] = sel_i[j];
                end else begin : g_zero
                    assign sel_o[j] = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wbd_resp_mux.sv
module wbd_resp_mux
    import wbd_pkg::*;
#(
    parameter int NUM_SUB = 4,
    parameter int DATA_W  = 32,
    parameter logic [NUM_SUB-1:0] HAS_ERR   = '0,
    parameter logic [NUM_SUB-1:0] HAS_RTY   = '0,
    parameter logic [NUM_SUB-1:0] HAS_STALL = '0
) (
    input  logic [NUM_SUB-1:0]        grant_i,
    input  logic [NUM_SUB*DATA_W-1:0] dat_i,
    input  logic [NUM_SUB-1:0]        ack_i,
    input  logic [NUM_SUB-1:0]        err_i,
    input  logic [NUM_SUB-1:0]        rty_i,
    input  logic [NUM_SUB-1:0]        stall_i,
    output logic [DATA_W-1:0]         dat_o,
    output wbd_resp_t                 resp_o
);
    wbd_resp_t [NUM_SUB-1:0] per_sub;

    generate
        for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
            always_comb begin
                per_sub[i].ack   = ack_i[i];
                per_sub[i].err   = HAS_ERR[i]   ? err_i[i]   : 1'b0;
                per_sub[i].rty   = HAS_RTY[i]   ? rty_i[i]   : 1'b0;
                per_sub[i].stall = HAS_STALL[i] ? stall_i[i] : 1'b0;
            end
        end
    endgenerate

    // grant is one-hot or zero, so an AND-OR tree is a mux
    always_comb begin
        dat_o  = '0;
        resp_o = '0;
        for (int i = 0; i < NUM_SUB; i++) begin
            if (grant_i[i]) begin
                dat_o  = dat_o | dat_i[i*DATA_W +: DATA_W];
                resp_o = resp_o | per_sub[i];
            end
        end
    end
endmodule

// File: rtl/wbd_addr_decoder.sv
module wbd_addr_decoder
    import wbd_pkg::*;
#(
    parameter int NUM_SUB = 4,
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    parameter int GRAN    = 16,
    parameter int SUB_AW  = 8,
    parameter logic [NUM_SUB-1:0][ADDR_W-1:0] SUB_BASE =
        {20'h04000, 20'h03000, 20'h02000, 20'h01000},
    parameter logic [NUM_SUB-1:0][7:0] SUB_SIZE_LOG2 = {8'd4, 8'd8, 8'd5, 8'd6},
    parameter logic [NUM_SUB-1:0] SUB_FINE      = 4'b1010,
    parameter logic [NUM_SUB-1:0] SUB_HAS_ERR   = 4'b0101,
    parameter logic [NUM_SUB-1:0] SUB_HAS_RTY   = 4'b0001,
    parameter logic [NUM_SUB-1:0] SUB_HAS_STALL = 4'b1001,
    localparam int SEL_W  = DATA_W / GRAN,
    localparam int FINE_W = DATA_W / 8
) (
    input  logic [ADDR_W-1:0]         m_adr_i,
    input  logic [DATA_W-1:0]         m_dat_w_i,
    input  logic [SEL_W-1:0]          m_sel_i,
    input  logic                      m_cyc_i,
    input  logic                      m_stb_i,
    input  logic                      m_we_i,
    input  logic                      m_lock_i,
    input  logic [CTI_W-1:0]          m_cti_i,
    input  logic [BTE_W-1:0]          m_bte_i,
    output logic [DATA_W-1:0]         m_dat_r_o,
    output logic                      m_ack_o,
    output logic                      m_err_o,
    output logic                      m_rty_o,
    output logic                      m_stall_o,
    output logic [NUM_SUB*SUB_AW-1:0] s_adr_o,
    output logic [DATA_W-1:0]         s_dat_w_o,
    output logic [NUM_SUB*FINE_W-1:0] s_sel_o,
    output logic [NUM_SUB-1:0]        s_cyc_o,
    output logic                      s_stb_o,
    output logic                      s_we_o,
    output logic                      s_lock_o,
    output logic [CTI_W-1:0]          s_cti_o,
    output logic [BTE_W-1:0]          s_bte_o,
    input  logic [NUM_SUB*DATA_W-1:0] s_dat_r_i,
    input  logic [NUM_SUB-1:0]        s_ack_i,
    input  logic [NUM_SUB-1:0]        s_err_i,
    input  logic [NUM_SUB-1:0]        s_rty_i,
    input  logic [NUM_SUB-1:0]        s_stall_i
);
    logic [NUM_SUB-1:0] hit;
    logic [NUM_SUB-1:0] grant;
    wbd_resp_t          resp;

    generate
        for (genvar i = 0; i < NUM_SUB; i++) begin : g_win
            wbd_window_match #(
                .ADDR_W    (ADDR_W),
                .SUB_AW    (SUB_AW),
                .SIZE_LOG2 (int'(SUB_SIZE_LOG2[i])),
                .BASE      (SUB_BASE[i])
            ) i_match (
                .adr_i    (m_adr_i),
                .hit_o    (hit[i]),
                .offset_o (s_adr_o[i*SUB_AW +: SUB_AW])
            );

            wbd_sel_widen #(
                .SEL_W  (SEL_W),
                .FINE_W (FINE_W),
                .FINE   (SUB_FINE[i])
            ) i_widen (
                .sel_i (m_sel_i),
                .sel_o (s_sel_o[i*FINE_W +: FINE_W])
            );
        end
    endgenerate

    // lowest index wins should windows ever overlap; gated by cycle
    always_comb begin
        grant = '0;
        for (int i = NUM_SUB - 1; i >= 0; i--) begin
            if (hit[i] && m_cyc_i) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    wbd_resp_mux #(
        .NUM_SUB   (NUM_SUB),
        .DATA_W    (DATA_W),
        .HAS_ERR   (SUB_HAS_ERR),
        .HAS_RTY   (SUB_HAS_RTY),
        .HAS_STALL (SUB_HAS_STALL)
    ) i_resp (
        .grant_i (grant),
        .dat_i   (s_dat_r_i),
        .ack_i   (s_ack_i),
        .err_i   (s_err_i),
        .rty_i   (s_rty_i),
        .stall_i (s_stall_i),
        .dat_o   (m_dat_r_o),
        .resp_o  (resp)
    );

    always_comb begin
        s_cyc_o   = grant;
        s_stb_o   = m_stb_i;
        s_we_o    = m_we_i;
        s_lock_o  = m_lock_i;
        s_cti_o   = m_cti_i;
        s_bte_o   = m_bte_i;
        s_dat_w_o = m_dat_w_i;
        m_ack_o   = resp.ack;
        m_err_o   = resp.err;
        m_rty_o   = resp.rty;
        m_stall_o = resp.stall;
    end
endmodule

// File: rtl/wbd_addr_decoder_chk.sv
module wbd_addr_decoder_chk #(
    parameter int NUM_SUB = 4,
    parameter int DATA_W  = 32,
    parameter int SUB_AW  = 8,
    parameter int SEL_W   = 2,
    parameter int FINE_W  = 4,
    parameter int ADDR_W  = 20,
    parameter logic [NUM_SUB-1:0] SUB_HAS_ERR   = '0,
    parameter logic [NUM_SUB-1:0] SUB_HAS_STALL = '0
) (
    input logic [ADDR_W-1:0]         m_adr_i,
    input logic [DATA_W-1:0]         m_dat_w_i,
    input logic                      m_cyc_i,
    input logic                      m_stb_i,
    input logic                      m_we_i,
    input logic                      m_lock_i,
    input logic [2:0]                m_cti_i,
    input logic [1:0]                m_bte_i,
    input logic [DATA_W-1:0]         m_dat_r_o,
    input logic                      m_ack_o,
    input logic                      m_err_o,
    input logic                      m_rty_o,
    input logic                      m_stall_o,
    input logic [DATA_W-1:0]         s_dat_w_o,
    input logic [NUM_SUB-1:0]        s_cyc_o,
    input logic                      s_stb_o,
    input logic                      s_we_o,
    input logic                      s_lock_o,
    input logic [2:0]                s_cti_o,
    input logic [1:0]                s_bte_o,
    input logic [NUM_SUB*DATA_W-1:0] s_dat_r_i,
    input logic [NUM_SUB-1:0]        s_ack_i
);
    always_comb begin
        p_cyc_onehot_r1: assert ($onehot0(s_cyc_o));
        if (!m_cyc_i) begin
            p_cyc_idle_r1: assert (s_cyc_o == '0);
        end
        p_broadcast_r2: assert (s_stb_o == m_stb_i && s_we_o == m_we_i &&
                                s_lock_o == m_lock_i && s_cti_o == m_cti_i &&
                                s_bte_o == m_bte_i && s_dat_w_o == m_dat_w_i);
        if (s_cyc_o == '0) begin
            p_miss_quiet_r8: assert (!m_ack_o && !m_err_o && !m_rty_o &&
                                     !m_stall_o && m_dat_r_o == '0);
        end
        for (int i = 0; i < NUM_SUB; i++) begin
            if (s_cyc_o[i]) begin
                p_ack_sel_r5: assert (m_ack_o == s_ack_i[i] &&
                                      m_dat_r_o == s_dat_r_i[i*DATA_W +: DATA_W]);
                if (!SUB_HAS_ERR[i]) begin
                    p_err_default_r6: assert (!m_err_o);
                end
                if (!SUB_HAS_STALL[i]) begin
                    p_stall_default_r7: assert (!m_stall_o);
                end
            end
        end
    end
endmodule

bind wbd_addr_decoder wbd_addr_decoder_chk #(
    .NUM_SUB       (NUM_SUB),
    .DATA_W        (DATA_W),
    .SUB_AW        (SUB_AW),
    .SEL_W         (SEL_W),
    .FINE_W        (FINE_W),
    .ADDR_W        (ADDR_W),
    .SUB_HAS_ERR   (SUB_HAS_ERR),
    .SUB_HAS_STALL (SUB_HAS_STALL)
) i_chk (.*);

// File: tb/test_wbd_addr_decoder.sv
module test_wbd_addr_decoder;
    localparam int NS = 4;
    localparam int AW = 20;
    localparam int DW = 32;
    localparam int SAW = 8;
    localparam int SW = 2;
    localparam int FW = 4;
    localparam logic [NS-1:0][AW-1:0] BASE =
        {20'h04000, 20'h03000, 20'h02000, 20'h01000};
    localparam logic [NS-1:0][7:0] SZ = {8'd4, 8'd8, 8'd5, 8'd6};
    localparam logic [NS-1:0] FINE  = 4'b1010;
    localparam logic [NS-1:0] H_ERR = 4'b0101;
    localparam logic [NS-1:0] H_RTY = 4'b0001;
    localparam logic [NS-1:0] H_STL = 4'b1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] m_adr;
    logic [DW-1:0] m_dat_w, m_dat_r;
    logic [SW-1:0] m_sel;
    logic m_cyc, m_stb, m_we, m_lock, m_ack, m_err, m_rty, m_stall;
    logic [2:0] m_cti, s_cti;
    logic [1:0] m_bte, s_bte;
    logic [NS*SAW-1:0] s_adr;
    logic [DW-1:0] s_dat_w;
    logic [NS*FW-1:0] s_sel;
    logic [NS-1:0] s_cyc, s_ack, s_err, s_rty, s_stall;
    logic s_stb, s_we, s_lock;
    logic [NS*DW-1:0] s_dat_r;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wbd_addr_decoder #(
        .NUM_SUB(NS), .ADDR_W(AW), .DATA_W(DW), .GRAN(16), .SUB_AW(SAW),
        .SUB_BASE(BASE), .SUB_SIZE_LOG2(SZ), .SUB_FINE(FINE),
        .SUB_HAS_ERR(H_ERR), .SUB_HAS_RTY(H_RTY), .SUB_HAS_STALL(H_STL)
    ) i_wbd_addr_decoder (
        .m_adr_i(m_adr), .m_dat_w_i(m_dat_w), .m_sel_i(m_sel), .m_cyc_i(m_cyc),
        .m_stb_i(m_stb), .m_we_i(m_we), .m_lock_i(m_lock), .m_cti_i(m_cti),
        .m_bte_i(m_bte), .m_dat_r_o(m_dat_r), .m_ack_o(m_ack), .m_err_o(m_err),
        .m_rty_o(m_rty), .m_stall_o(m_stall), .s_adr_o(s_adr), .s_dat_w_o(s_dat_w),
        .s_sel_o(s_sel), .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we),
        .s_lock_o(s_lock), .s_cti_o(s_cti), .s_bte_o(s_bte), .s_dat_r_i(s_dat_r),
        .s_ack_i(s_ack), .s_err_i(s_err), .s_rty_i(s_rty), .s_stall_i(s_stall)
    );

    // address-echo subordinates: each enabled lane returns its address plus lane index
    always_comb begin
        s_dat_r = '0;
        for (int i = 0; i < NS; i++) begin
            if (FINE[i]) begin
                for (int j = 0; j < 4; j++)
                    if (s_sel[i*FW + j])
                        s_dat_r[i*DW + 8*j +: 8] = s_adr[i*SAW +: SAW] + 8'(j);
            end else begin
                for (int k = 0; k < 2; k++)
                    if (s_sel[i*FW + k])
                        s_dat_r[i*DW + 16*k +: 16] = {8'h00, s_adr[i*SAW +: SAW]} + 16'(k);
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_dat(int i, logic [7:0] off, logic [1:0] sel);
        logic [DW-1:0] r = '0;
        if (FINE[i]) begin
            for (int j = 0; j < 4; j++)
                if (sel[j/2]) r[8*j +: 8] = off + 8'(j);
        end else begin
            for (int k = 0; k < 2; k++)
                if (sel[k]) r[16*k +: 16] = {8'h00, off} + 16'(k);
        end
        return r;
    endfunction

    function automatic logic [FW-1:0] exp_sel(int i, logic [1:0] sel);
        if (FINE[i]) return {sel[1], sel[1], sel[0], sel[0]};
        return {2'b00, sel};
    endfunction

    task automatic drive(logic [AW-1:0] a, logic [1:0] sel, logic cyc);
        @(posedge clk);
        #1;
        m_adr = a;
        m_sel = sel;
        m_cyc = cyc;
        @(negedge clk);
    endtask

    task automatic t_idle();
        drive(BASE[0], 2'b11, 1'b0);
        chk("R1 idle cyc", 64'(s_cyc), 64'd0);
        chk("R8 idle resp", {m_ack, m_err, m_rty, m_stall}, 64'd0);
        chk("R8 idle data", 64'(m_dat_r), 64'd0);
    endtask

    task automatic t_hit(int i, logic [7:0] off, logic [1:0] sel);
        drive(BASE[i] + AW'(off), sel, 1'b1);
        chk($sformatf("R1 cyc sub%0d", i), 64'(s_cyc), 64'(1 << i));
        chk($sformatf("R3 offset sub%0d", i), 64'(s_adr[i*SAW +: SAW]), 64'(off));
        if (FINE[i]) chk($sformatf("R10 sel sub%0d", i), 64'(s_sel[i*FW +: FW]), 64'(exp_sel(i, sel)));
        else         chk($sformatf("R9 sel sub%0d", i),  64'(s_sel[i*FW +: FW]), 64'(exp_sel(i, sel)));
        chk($sformatf("R5 data sub%0d sel%b", i, sel), 64'(m_dat_r), 64'(exp_dat(i, off, sel)));
    endtask

    task automatic t_broadcast();
        m_stb = 1'b1; m_we = 1'b1; m_lock = 1'b1; m_cti = 3'd2; m_bte = 2'd1;
        m_dat_w = 32'h1234_5678;
        drive(BASE[2] + 20'd3, 2'b01, 1'b1);
        chk("R2 broadcast", {s_stb, s_we, s_lock, s_cti, s_bte, s_dat_w},
            {1'b1, 1'b1, 1'b1, 3'd2, 2'd1, 32'h1234_5678});
        m_stb = 1'b0; m_we = 1'b0; m_lock = 1'b0; m_cti = 3'd7; m_bte = 2'd3;
        m_dat_w = 32'hCAFE_0001;
        drive(BASE[1] + 20'd1, 2'b10, 1'b1);
        chk("R2 broadcast alt", {s_stb, s_we, s_lock, s_cti, s_bte, s_dat_w},
            {1'b0, 1'b0, 1'b0, 3'd7, 2'd3, 32'hCAFE_0001});
    endtask

    task automatic t_bounds();
        for (int i = 0; i < NS; i++) begin
            drive(BASE[i] + AW'((1 << SZ[i]) - 1), 2'b11, 1'b1);
            chk($sformatf("R4 last word sub%0d", i), 64'(s_cyc), 64'(1 << i));
            drive(BASE[i] + AW'(1 << SZ[i]), 2'b11, 1'b1);
            chk($sformatf("R4 past end sub%0d", i), 64'(s_cyc), 64'd0);
            chk($sformatf("R8 miss resp sub%0d", i), {m_ack, m_err, m_rty, m_stall, m_dat_r}, 64'd0);
            drive(BASE[i] - 20'd1, 2'b11, 1'b1);
            chk($sformatf("R4 below base sub%0d", i), 64'(s_cyc), 64'd0);
        end
    endtask

    task automatic t_resp();
        s_ack = '1; s_err = '1; s_rty = '1; s_stall = '1;
        for (int i = 0; i < NS; i++) begin
            drive(BASE[i] + 20'd2, 2'b11, 1'b1);
            chk($sformatf("R5 ack sub%0d", i), 64'(m_ack), 64'd1);
            chk($sformatf("R6 err/rty sub%0d", i), {m_err, m_rty}, {H_ERR[i], H_RTY[i]});
            chk($sformatf("R7 stall sub%0d", i), 64'(m_stall), 64'(H_STL[i]));
            s_ack = ~(NS'(1) << i);
            s_err = ~(NS'(1) << i); s_rty = ~(NS'(1) << i); s_stall = ~(NS'(1) << i);
            drive(BASE[i] + 20'd2, 2'b11, 1'b1);
            chk($sformatf("R5 others ignored sub%0d", i), {m_ack, m_err, m_rty, m_stall}, 64'd0);
            s_ack = '1; s_err = '1; s_rty = '1; s_stall = '1;
        end
        drive(20'h0_0000, 2'b11, 1'b1);
        chk("R8 miss with live responses", {m_ack, m_err, m_rty, m_stall, m_dat_r}, 64'd0);
        s_ack = '0; s_err = '0; s_rty = '0; s_stall = '0;
    endtask

    initial begin
        m_adr = '0; m_sel = '0; m_cyc = 0; m_stb = 0; m_we = 0; m_lock = 0;
        m_cti = '0; m_bte = '0; m_dat_w = '0;
        s_ack = '0; s_err = '0; s_rty = '0; s_stall = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        for (int i = 0; i < NS; i++)
            for (int s = 0; s < 4; s++)
                t_hit(i, 8'(5 + i), 2'(s));
        t_hit(2, 8'hF0, 2'b11);
        t_hit(0, 8'h00, 2'b10);
        t_broadcast();
        t_bounds();
        t_resp();
        t_idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule